// File: doc/BRIEF.md
# Indirect Register Port with Interrupt Merge

This block is a byte-wide slave on a host bus. The bus has an active-low select, active-low read and write strobes, and a 2-bit address. Behind those four addresses sit four locations: an interrupt word, a read-only status byte passed in from the rest of the chip, an index register, and a data window. Through the data window the host reaches a bank of 64 byte-wide registers inside the block.

When the auto-step flag is set in the index register, every access through the data window moves the index on by one. This lets the host walk a run of consecutive registers without rewriting the index.

Four event inputs are single-cycle pulses from the peripherals. Each one sets a pending flag. The host enables each flag separately, and `irq` goes high whenever an enabled flag is pending. A read of the interrupt word returns its value as it was before the read and then drops every pending flag. The strobes arrive asynchronously and are synchronized inside the block. Every bus access is a plain strobe cycle, so no valid/ready handshake exists at any port and no back-pressure applies.

Top module: `hbus_regfile`

## Requirements
- R1: A read at address 1 returns the byte present on `gen_status` when the access is taken.
- R2: Writing a value at address 2 sets the index from bits 5:0. A write or read at address 3 then stores into, or returns, the bank entry at that index.
- R3: With bit 7 of address 2 set, each access at address 3 advances the index by exactly one, and the index wraps from 63 to 0. With bit 7 clear, the index is unchanged by such accesses.
- R4: A read at address 2 returns the auto-step flag in bit 7, zero in bit 6, and the index in bits 5:0.
- R5: Address 0 reads as {rx pending, tx pending, line pending, rx enable, tx enable, line enable, timer pending, timer enable}, from bit 7 down to bit 0. A write there changes only bits 4, 3, 2 and 0, and it never alters a pending flag.
- R6: A pulse on an event input sets its pending flag on the next clock edge. `irq` is high exactly while some pending flag has its enable set.
- R7: A read at address 0 returns the value from before the read, then clears every pending flag, so `irq` falls.
- R8: An event pulse in the same cycle as a clearing read of address 0 stays pending.
- R9: A strobe held low for many cycles counts as one access, so the index advances only once.
- R10: An access takes effect, and `rdata` changes, on the third rising clock edge after the strobe is driven low. `rdata` holds between reads, and strobes with `cs_n` high are ignored.
- R11: After reset the bank, index, flags, enables and `rdata` are zero, and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low select |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe |
| addr | input | 2 | Register address, held stable while a strobe is low |
| wdata | input | 8 | Write byte, held stable while a strobe is low |
| rdata | output | 8 | Byte captured by the latest read |
| gen_status | input | 8 | Status byte presented at address 1 |
| ev_ltc_rx | input | 1 | Receive-frame event pulse |
| ev_ltc_tx | input | 1 | Transmit-load event pulse |
| ev_vline | input | 1 | Video-line event pulse |
| ev_timer | input | 1 | Timer event pulse |
| irq | output | 1 | Active-high interrupt request |

## Verification
A strobe's effect lands on the third rising edge after the strobe falls: two synchronizer stages, then the access edge. The bench therefore samples `rdata` three falling edges after it asserts a strobe. For the timing requirement it also confirms that `rdata` still holds its old value one edge earlier. An event sets `irq` at the next rising edge, and the bench checks it at the following falling edge. For the coincident-event case, the event pulse is placed so that it spans exactly the access edge. Between strobes the bench waits three cycles, so that every strobe is seen as a fresh falling edge.

// File: rtl/hbus_pkg.sv
package hbus_pkg;
  typedef enum logic [1:0] {
    REG_IRQ  = 2'd0,
    REG_STAT = 2'd1,
    REG_IDX  = 2'd2,
    REG_DATA = 2'd3
  } hreg_e;

  localparam int NSRC    = 4;
  localparam int SRC_LRX = 0;
  localparam int SRC_LTX = 1;
  localparam int SRC_VLN = 2;
  localparam int SRC_TMR = 3;

  // interrupt word packing: bit order is visible to host software
  function automatic logic [7:0] pack_irq(input logic [NSRC-1:0] f, input logic [NSRC-1:0] e);
    return {f[SRC_LRX], f[SRC_LTX], f[SRC_VLN], e[SRC_LRX], e[SRC_LTX], e[SRC_VLN],
            f[SRC_TMR], e[SRC_TMR]};
  endfunction

  function automatic logic [NSRC-1:0] unpack_en(input logic [7:0] b);
    logic [NSRC-1:0] e;
    e[SRC_LRX] = b[4];
    e[SRC_LTX] = b[3];
    e[SRC_VLN] = b[2];
    e[SRC_TMR] = b[0];
    return e;
  endfunction
endpackage

// File: rtl/hbus_sync.sv
module hbus_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[s] <= RST_VAL;
        else if (s == 0) chain[s] <= d;
        else chain[s] <= chain[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/hbus_irq.sv
module hbus_irq
  import hbus_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] ev,
  input  logic            en_we,
  input  logic [NSRC-1:0] en_d,
  input  logic            clr,
  output logic [NSRC-1:0] flags,
  output logic [NSRC-1:0] en,
  output logic            irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags <= '0;
      en    <= '0;
    end else begin
      // new events win over a coincident clear
      flags <= (clr ? '0 : flags) | ev;
      if (en_we) en <= en_d;
    end
  end

  assign irq = |(flags & en);
endmodule

// File: rtl/hbus_bank.sv
module hbus_bank #(
  parameter int NREG = 64,
  parameter int DW   = 8,
  localparam int IDXW = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            idx_we,
  input  logic            acc,
  input  logic            acc_we,
  input  logic [DW-1:0]   wdata,
  output logic [IDXW-1:0] idx,
  output logic            ainc,
  output logic [DW-1:0]   word
);
  logic [DW-1:0] mem [NREG];
  logic unused_mid;

  assign unused_mid = ^wdata[DW-2:IDXW];
  assign word = mem[idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx  <= '0;
      ainc <= 1'b0;
    end else if (idx_we) begin
      idx  <= wdata[IDXW-1:0];
      ainc <= wdata[DW-1];
    end else if (acc && ainc) begin
      idx <= idx + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) mem[i] <= '0;
    end else if (acc && acc_we) begin
      mem[idx] <= wdata;
    end
  end
endmodule

// File: rtl/hbus_regfile.sv
module hbus_regfile
  import hbus_pkg::*;
#(
  parameter int NREG   = 64,
  parameter int DW     = 8,
  parameter int STAGES = 2,
  localparam int IDXW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          rd_n,
  input  logic          wr_n,
  input  logic [1:0]    addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic [DW-1:0] gen_status,
  input  logic          ev_ltc_rx,
  input  logic          ev_ltc_tx,
  input  logic          ev_vline,
  input  logic          ev_timer,
  output logic          irq
);
  logic [2:0]      strb_s;
  logic            rd_act, wr_act, rd_act_q, wr_act_q;
  logic            rd_go, wr_go;
  logic [NSRC-1:0] ev, flags, en;
  logic [IDXW-1:0] idx;
  logic            ainc;
  logic [DW-1:0]   word;
  hreg_e           sel;

  hbus_sync #(.WIDTH(3), .STAGES(STAGES), .RST_VAL(3'b111)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({cs_n, rd_n, wr_n}), .q(strb_s)
  );

  assign rd_act = !strb_s[2] && !strb_s[1];
  assign wr_act = !strb_s[2] && !strb_s[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_act_q <= 1'b0;
      wr_act_q <= 1'b0;
    end else begin
      rd_act_q <= rd_act;
      wr_act_q <= wr_act;
    end
  end

  assign rd_go = rd_act && !rd_act_q;
  assign wr_go = wr_act && !wr_act_q;
  assign sel   = hreg_e'(addr);

  always_comb begin
    ev = '0;
    ev[SRC_LRX] = ev_ltc_rx;
    ev[SRC_LTX] = ev_ltc_tx;
    ev[SRC_VLN] = ev_vline;
    ev[SRC_TMR] = ev_timer;
  end

  hbus_irq u_irq (
    .clk(clk), .rst_n(rst_n), .ev(ev),
    .en_we(wr_go && sel == REG_IRQ), .en_d(unpack_en(wdata)),
    .clr(rd_go && sel == REG_IRQ),
    .flags(flags), .en(en), .irq(irq)
  );

  hbus_bank #(.NREG(NREG), .DW(DW)) u_bank (
    .clk(clk), .rst_n(rst_n),
    .idx_we(wr_go && sel == REG_IDX),
    .acc((rd_go || wr_go) && sel == REG_DATA),
    .acc_we(wr_go),
    .wdata(wdata), .idx(idx), .ainc(ainc), .word(word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata <= '0;
    else if (rd_go) begin
      unique case (sel)
        REG_IRQ:  rdata <= pack_irq(flags, en);
        REG_STAT: rdata <= gen_status;
        REG_IDX:  rdata <= DW'({ainc, 1'b0, (DW-2)'(idx)});
        REG_DATA: rdata <= word;
      endcase
    end
  end
endmodule

// File: rtl/hbus_regfile_chk.sv
module hbus_regfile_chk #(
  parameter int IDXW = 6,
  parameter int DW   = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            rd_go,
  input logic            wr_go,
  input logic [1:0]      addr,
  input logic [3:0]      ev,
  input logic [3:0]      flags,
  input logic [3:0]      en,
  input logic            irq,
  input logic            ainc,
  input logic [IDXW-1:0] idx,
  input logic [DW-1:0]   rdata
);
  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd_go || wr_go) && addr == 2'd3 && ainc) |=> (idx == IDXW'($past(idx) + 1'b1))); // R3
  AST_STEP_NONE: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd_go || wr_go) && addr == 2'd3 && !ainc) |=> $stable(idx)); // R3
  AST_EN_ONLY_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_go && addr == 2'd0) |=> $stable(en)); // R5
  AST_IDLE_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (flags == 4'd0) |-> !irq); // R6
  AST_CLEAR_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_go && addr == 2'd0 && ev == 4'd0) |=> (flags == 4'd0)); // R7
  AST_EVENT_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (ev != 4'd0) |=> ((flags & $past(ev)) == $past(ev))); // R8
  AST_SINGLE_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    rd_go |=> !rd_go); // R9
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_go |=> $stable(rdata)); // R10
endmodule

bind hbus_regfile hbus_regfile_chk #(.IDXW(IDXW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_go(rd_go), .wr_go(wr_go), .addr(addr),
  .ev(ev), .flags(flags), .en(en), .irq(irq), .ainc(ainc), .idx(idx), .rdata(rdata)
);

// File: tb/hbus_regfile_test.sv
module hbus_regfile_test;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       cs_n = 1, rd_n = 1, wr_n = 1;
  logic [1:0] addr = 0;
  logic [7:0] wdata = 0, gen_status = 0;
  logic       ev_ltc_rx = 0, ev_ltc_tx = 0, ev_vline = 0, ev_timer = 0;
  logic [7:0] rdata;
  logic       irq;

  int checks = 0, fails = 0;
  bit done = 0;

  typedef struct { logic [7:0] data; string req; } exp_t;
  exp_t exp_q[$];
  event rd_done;

  always #5 clk = ~clk;

  hbus_regfile uut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .addr(addr), .wdata(wdata), .rdata(rdata), .gen_status(gen_status),
    .ev_ltc_rx(ev_ltc_rx), .ev_ltc_tx(ev_ltc_tx), .ev_vline(ev_vline),
    .ev_timer(ev_timer), .irq(irq)
  );

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  // monitor: compares each completed read against the scoreboard
  initial forever begin
    exp_t e;
    @(rd_done);
    e = exp_q.pop_front();
    check(e.req, rdata, e.data);
  end

  task automatic host_write(logic [1:0] a, logic [7:0] d, bit sel = 1);
    @(negedge clk); cs_n = !sel; wr_n = 0; addr = a; wdata = d;
    repeat (3) @(negedge clk);
    cs_n = 1; wr_n = 1;
    repeat (3) @(negedge clk);
  endtask

  task automatic host_read(logic [1:0] a, logic [7:0] exp, string req, int hold = 0);
    exp_q.push_back('{exp, req});
    @(negedge clk); cs_n = 0; rd_n = 0; addr = a;
    repeat (3) @(negedge clk);
    -> rd_done;
    repeat (hold) @(negedge clk);
    cs_n = 1; rd_n = 1;
    repeat (3) @(negedge clk);
  endtask

  task automatic pulse_timer(); @(negedge clk); ev_timer = 1; @(negedge clk); ev_timer = 0; endtask
  task automatic pulse_rx();    @(negedge clk); ev_ltc_rx = 1; @(negedge clk); ev_ltc_rx = 0; endtask
  task automatic pulse_txvl();
    @(negedge clk); ev_ltc_tx = 1; ev_vline = 1; @(negedge clk); ev_ltc_tx = 0; ev_vline = 0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R11 irq", {7'd0, irq}, 8'h00);
    check("R11 rdata", rdata, 8'h00);

    // R10 timing plus R1 status passthrough
    gen_status = 8'hA5;
    @(negedge clk); cs_n = 0; rd_n = 0; addr = 2'd1;
    repeat (2) @(negedge clk);
    check("R10 not before third edge", rdata, 8'h00);
    @(negedge clk);
    check("R1 status read", rdata, 8'hA5);
    cs_n = 1; rd_n = 1;
    repeat (3) @(negedge clk);

    // R2 basic indirect access, no auto-step
    host_write(2'd2, 8'h05);
    host_write(2'd3, 8'h3C);
    host_read(2'd3, 8'h3C, "R2 indirect readback");
    host_read(2'd2, 8'h05, "R3 no step without flag");

    // R4 bit 6 reads zero; R3 auto-step with wrap
    host_write(2'd2, 8'hFE);
    host_read(2'd2, 8'hBE, "R4 index readback");
    host_write(2'd3, 8'h11);
    host_write(2'd3, 8'h22);
    host_write(2'd3, 8'h33);
    host_read(2'd2, 8'h81, "R3 wrap 63 to 0");
    host_write(2'd2, 8'h3E); host_read(2'd3, 8'h11, "R3 entry 62");
    host_write(2'd2, 8'h3F); host_read(2'd3, 8'h22, "R3 entry 63");
    host_write(2'd2, 8'h00); host_read(2'd3, 8'h33, "R3 entry 0");
    host_write(2'd2, 8'h85); host_read(2'd3, 8'h3C, "R2 entry 5 kept");
    host_read(2'd2, 8'h86, "R3 read steps index");

    // R9 long strobe counts once
    host_write(2'd2, 8'h80);
    host_read(2'd3, 8'h33, "R9 long read data", 20);
    host_read(2'd2, 8'h81, "R9 single step");

    // R5 only enable bits writable
    host_write(2'd0, 8'hFF);
    host_read(2'd0, 8'h1D, "R5 enable mask");

    // R6 / R7
    pulse_timer();
    check("R6 irq after timer event", {7'd0, irq}, 8'h01);
    host_read(2'd0, 8'h1F, "R7 pre-clear value");
    check("R7 irq dropped", {7'd0, irq}, 8'h00);
    host_read(2'd0, 8'h1D, "R7 flags cleared");

    // R6 disabled sources and layout
    host_write(2'd0, 8'h00);
    pulse_rx();
    check("R6 masked source", {7'd0, irq}, 8'h00);
    host_read(2'd0, 8'h80, "R5 rx pending bit 7");
    pulse_txvl();
    host_write(2'd0, 8'h08);
    check("R6 enable after pending", {7'd0, irq}, 8'h01);
    host_read(2'd0, 8'h68, "R5 write keeps pending");

    // R8 event coincident with clearing read
    host_write(2'd0, 8'h01);
    exp_q.push_back('{8'h01, "R8 coincident read value"});
    @(negedge clk); cs_n = 0; rd_n = 0; addr = 2'd0;
    @(negedge clk);
    @(negedge clk); ev_timer = 1;
    @(negedge clk); ev_timer = 0;
    -> rd_done;
    cs_n = 1; rd_n = 1;
    repeat (3) @(negedge clk);
    check("R8 irq still pending", {7'd0, irq}, 8'h01);
    host_read(2'd0, 8'h03, "R8 flag kept");

    // R10 deselected strobe ignored
    host_write(2'd2, 8'h00, 0);
    host_read(2'd2, 8'h81, "R10 cs high ignored");

    repeat (5) @(negedge clk);
    done = 1;
    finish_run();
  end
endmodule